// File: doc/BRIEF.md
# Radix-4 Traceback Unit

This block sits after a radix-4 add-compare-select array in a convolutional decoder. On every accepted trellis step it receives, for each encoder state, a 2-bit decision that names which of four predecessors survived. It also receives the index of the state that currently holds the smallest path metric. The decision words go into a small circular store. A combinational chain then walks backward from the best state through a window of trellis stages and releases two decoded bits per accepted step.

Each radix-4 step covers two trellis stages, so a depth of 42 stages takes 21 backward steps. The walk result passes through a delay line, and the decoded pair appears a fixed number of clocks after the input that produced it. The output flag stays low while the window is still filling after enable. Once the window is full, the flag follows the delayed input strobe, including any gaps in it. Decoding runs as a continuous stream. When the input stops, the only flushing is the drain of the delay line.

Top module: `radix4_traceback`

## Requirements
- R1: While reset is high and in the first cycle after it, `vld_o` is low and `bits_o` is `2'b00`.
- R2: An accepted input (`en_i` and `vld_i` both high at a rising edge) whose window is full raises `vld_o` at the LATENCY-th rising edge, counting the sampling edge as the first. No other cycle has `vld_o` high.
- R3: The backward walk starts at `best_i`. From state s, the next state is the 2-bit decision at bits [2s+1:2s] of that step's decision word placed above bits [STATE_BITS-1:2] of s. The word sampled with the input is used first, then older stored words, newest first.
- R4: After TB_DEPTH/2 steps, `bits_o[1]` is bit 1 (the older bit) and `bits_o[0]` is bit 0 (the newer bit) of the state reached. On an encoder-consistent stream this equals the data pair of the trellis step TB_DEPTH/2 steps earlier.
- R5: After reset, and after each time `en_i` returns high, the first TB_DEPTH/2 accepted inputs produce no valid output.
- R6: A cycle with `en_i` high and `vld_i` low stores nothing and does not advance the trellis. It gives `vld_o` low in its matching output cycle, and decoding continues correctly across the gap.
- R7: While `en_i` is low, `vld_i` and the decision inputs are ignored and the fill count is cleared. Results already in flight still drain.
- R8: `bits_o` is `2'b00` in every cycle where `vld_o` is low.
- R9: The survivor store is a ring of BUF_STAGES words, with BUF_STAGES at least TB_DEPTH/2-1. Decoding stays correct across many wraps of its write pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Decoder enable; low clears the fill count |
| vld_i | input | 1 | Decision word and best state are valid this cycle |
| dec_i | input | 2*2^STATE_BITS | Per-state 2-bit survivor decisions; state s at bits [2s+1:2s] |
| best_i | input | STATE_BITS | Index of the state with the minimum metric |
| bits_o | output | 2 | Decoded pair; bit 1 is the older bit |
| vld_o | output | 1 | Marks a valid decoded pair |

## Verification
The bench builds the block with 16 states, a depth of 8 stages (4 backward steps), a 5-word ring and a latency of 7. This keeps the per-state decision tables small enough to fill with fresh random content on every step. The ring wraps more than a hundred times during the run. Fill, drain and latency boundaries are reached within a few cycles of each phase change. With these values, every output cycle can be checked against an encoder-consistent path and against a walk from arbitrary best states. The checks cover continuous input, input with random gaps, and enable dropouts.

// File: rtl/tbu_pkg.sv
`timescale 1ns/1ps
package tbu_pkg;

    // Defaults for the full-size decoder.
    localparam int unsigned TBU_STATE_BITS = 6;
    localparam int unsigned TBU_DEPTH      = 42;
    localparam int unsigned TBU_BUF_STAGES = 24;
    localparam int unsigned TBU_LATENCY    = 47;

    // One slot of the output delay line.
    typedef struct packed {
        logic       vld;
        logic [1:0] bits;
    } tbu_out_t;

    localparam tbu_out_t TBU_OUT_IDLE = '{vld: 1'b0, bits: 2'b00};

endpackage

// File: rtl/tbu_surv_ring.sv
`timescale 1ns/1ps
module tbu_surv_ring #(
    parameter int unsigned DEC_W      = 128,
    parameter int unsigned BUF_STAGES = 24,
    parameter int unsigned AGES       = 20
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en_i,
    input  logic [DEC_W-1:0]           wr_data_i,
    output logic [AGES-1:0][DEC_W-1:0] aged_o
);

    localparam int unsigned PTR_W = $clog2(BUF_STAGES);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(BUF_STAGES - 1);

    logic [BUF_STAGES-1:0][DEC_W-1:0] mem_q;
    logic [PTR_W-1:0]                 wptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
        end else if (wr_en_i) begin
            wptr_q <= (wptr_q == PTR_LAST) ? '0 : wptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            mem_q[wptr_q] <= wr_data_i;
        end
    end

    // Word of age a (a = g+1) sits a slots behind the write pointer.
    for (genvar g = 0; g < AGES; g++) begin : g_age
        localparam logic [PTR_W:0] OFS  = (PTR_W+1)'(BUF_STAGES - g - 1);
        localparam logic [PTR_W:0] WRAP = (PTR_W+1)'(BUF_STAGES);
        logic [PTR_W:0] sum;
        logic [PTR_W:0] idx;
        always_comb begin
            sum = {1'b0, wptr_q} + OFS;
            idx = (sum >= WRAP) ? sum - WRAP : sum;
        end
        assign aged_o[g] = mem_q[idx[PTR_W-1:0]];
    end

endmodule

// File: rtl/tbu_walk.sv
`timescale 1ns/1ps
module tbu_walk #(
    parameter int unsigned STATE_BITS = 6,
    parameter int unsigned STEPS      = 21,
    localparam int unsigned DEC_W     = 2 * (1 << STATE_BITS)
) (
    input  logic [DEC_W-1:0]            newest_i,
    input  logic [STEPS-2:0][DEC_W-1:0] aged_i,
    input  logic [STATE_BITS-1:0]       start_i,
    output logic [1:0]                  bits_o
);

    logic [STEPS-1:0][DEC_W-1:0] words;
    logic [STATE_BITS-1:0]       st;

    assign words = {aged_i, newest_i};

    // Each step moves to the predecessor: decision on top, two low bits dropped.
    always_comb begin
        st = start_i;
        for (int k = 0; k < int'(STEPS); k++) begin
            st = {words[k][{st, 1'b0} +: 2], st[STATE_BITS-1:2]};
        end
        bits_o = st[1:0];
    end

endmodule

// File: rtl/tbu_out_pipe.sv
`timescale 1ns/1ps
module tbu_out_pipe
    import tbu_pkg::*;
#(
    parameter int unsigned STEPS   = 21,
    parameter int unsigned LATENCY = 47
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       acc_i,
    input  logic       en_i,
    input  logic [1:0] bits_i,
    output tbu_out_t   out_o
);

    localparam int unsigned FILL_W = $clog2(STEPS + 1);
    localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(STEPS);

    logic [FILL_W-1:0]         fill_q;
    logic                      full;
    tbu_out_t                  head;
    tbu_out_t [LATENCY-1:0]    pipe_q;

    assign full = (fill_q == FILL_MAX);

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            fill_q <= '0;
        end else if (acc_i && !full) begin
            fill_q <= fill_q + 1'b1;
        end
    end

    always_comb begin
        head      = TBU_OUT_IDLE;
        head.vld  = acc_i && full;
        head.bits = head.vld ? bits_i : 2'b00;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '0;
        end else begin
            pipe_q[0] <= head;
            for (int i = 1; i < int'(LATENCY); i++) begin
                pipe_q[i] <= pipe_q[i-1];
            end
        end
    end

    assign out_o = pipe_q[LATENCY-1];

endmodule

// File: rtl/radix4_traceback.sv
`timescale 1ns/1ps
module radix4_traceback
    import tbu_pkg::*;
#(
    parameter int unsigned STATE_BITS = TBU_STATE_BITS,
    parameter int unsigned TB_DEPTH   = TBU_DEPTH,
    parameter int unsigned BUF_STAGES = TBU_BUF_STAGES,
    parameter int unsigned LATENCY    = TBU_LATENCY,
    localparam int unsigned DEC_W     = 2 * (1 << STATE_BITS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en_i,
    input  logic                  vld_i,
    input  logic [DEC_W-1:0]      dec_i,
    input  logic [STATE_BITS-1:0] best_i,
    output logic [1:0]            bits_o,
    output logic                  vld_o
);

    localparam int unsigned STEPS = TB_DEPTH / 2;
    localparam int unsigned AGES  = STEPS - 1;

    logic                        acc;
    logic [AGES-1:0][DEC_W-1:0]  aged;
    logic [1:0]                  walk_bits;
    tbu_out_t                    out_slot;

    assign acc = en_i && vld_i;

    tbu_surv_ring #(
        .DEC_W      (DEC_W),
        .BUF_STAGES (BUF_STAGES),
        .AGES       (AGES)
    ) u_ring (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (acc),
        .wr_data_i (dec_i),
        .aged_o    (aged)
    );

    tbu_walk #(
        .STATE_BITS (STATE_BITS),
        .STEPS      (STEPS)
    ) u_walk (
        .newest_i (dec_i),
        .aged_i   (aged),
        .start_i  (best_i),
        .bits_o   (walk_bits)
    );

    tbu_out_pipe #(
        .STEPS   (STEPS),
        .LATENCY (LATENCY)
    ) u_pipe (
        .clk    (clk),
        .rst    (rst),
        .acc_i  (acc),
        .en_i   (en_i),
        .bits_i (walk_bits),
        .out_o  (out_slot)
    );

    assign bits_o = out_slot.bits;
    assign vld_o  = out_slot.vld;

endmodule

// File: rtl/radix4_traceback_chk.sv
`timescale 1ns/1ps
module radix4_traceback_chk #(
    parameter int unsigned LATENCY = 47
) (
    input logic       clk,
    input logic       rst,
    input logic       en_i,
    input logic       vld_i,
    input logic [1:0] bits_o,
    input logic       vld_o
);

    localparam int unsigned CW = $clog2(LATENCY + 1);
    localparam logic [CW-1:0] CMAX = CW'(LATENCY);

    logic [CW-1:0] idle_cnt;
    logic [CW-1:0] off_cnt;

    // Streaks of edges with no accepted input / with enable low.
    always_ff @(posedge clk) begin
        if (rst) begin
            idle_cnt <= '0;
            off_cnt  <= '0;
        end else begin
            if (en_i && vld_i) idle_cnt <= '0;
            else if (idle_cnt != CMAX) idle_cnt <= idle_cnt + 1'b1;
            if (en_i) off_cnt <= '0;
            else if (off_cnt != CMAX) off_cnt <= off_cnt + 1'b1;
        end
    end

    assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!vld_o && bits_o == 2'b00));

    assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (rst)
        (idle_cnt >= CMAX) |-> !vld_o);

    assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (off_cnt >= CMAX) |-> !vld_o);

    assert_idle_bits_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !vld_o |-> (bits_o == 2'b00));

endmodule

bind radix4_traceback radix4_traceback_chk #(
    .LATENCY (LATENCY)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .en_i   (en_i),
    .vld_i  (vld_i),
    .bits_o (bits_o),
    .vld_o  (vld_o)
);

// File: tb/radix4_traceback_tb.sv
`timescale 1ns/1ps
module radix4_traceback_tb;

    localparam int SB    = 4;
    localparam int NS    = 1 << SB;
    localparam int W     = 2 * NS;
    localparam int DEPTH = 8;
    localparam int STEPS = DEPTH / 2;
    localparam int BUFS  = 5;
    localparam int LAT   = 7;
    localparam int MAXC  = 2048;

    logic          clk = 1'b0;
    logic          rst;
    logic          en_i;
    logic          vld_i;
    logic [W-1:0]  dec_i;
    logic [SB-1:0] best_i;
    logic [1:0]    bits_o;
    logic          vld_o;

    always #2 clk = ~clk;

    radix4_traceback #(
        .STATE_BITS (SB),
        .TB_DEPTH   (DEPTH),
        .BUF_STAGES (BUFS),
        .LATENCY    (LAT)
    ) u_dut (
        .clk    (clk),
        .rst    (rst),
        .en_i   (en_i),
        .vld_i  (vld_i),
        .dec_i  (dec_i),
        .best_i (best_i),
        .bits_o (bits_o),
        .vld_o  (vld_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    int g     = 0;
    int fb    = 0;
    logic [SB-1:0] cur_st = '0;
    bit done = 0;

    logic         exp_v [MAXC];
    logic [1:0]   exp_b [MAXC];
    string        exp_r [MAXC];
    logic [W-1:0] dec_hist  [MAXC];
    logic [1:0]   pair_hist [MAXC];

    function automatic logic [1:0] model_walk(int stage, logic [SB-1:0] s0);
        logic [SB-1:0] s = s0;
        for (int j = 0; j < STEPS; j++) begin
            logic [W-1:0] w = dec_hist[stage - j];
            s = {w[{s, 1'b0} +: 2], s[SB-1:2]};
        end
        return s[1:0];
    endfunction

    task automatic compare(string req, logic act_v, logic exp_vv, logic [1:0] act_b, logic [1:0] exp_bb);
        n_cmp++;
        if (act_v !== exp_vv || act_b !== exp_bb) begin
            n_bad++;
            $display("FAIL %s: vld_o=%0b bits_o=%0b expected vld_o=%0b bits_o=%0b (cycle %0d)",
                     req, act_v, act_b, exp_vv, exp_bb, cyc);
        end
    endtask

    // One clock: drive at the falling edge, check the output one edge later.
    task automatic step(logic en, logic v, bit rnd_best);
        logic [W-1:0]  word;
        logic [SB-1:0] prev;
        logic [1:0]    pair;
        int k;
        for (int s = 0; s < NS; s++) word[2*s +: 2] = 2'($urandom);
        best_i = SB'($urandom);
        exp_v[cyc] = 1'b0;
        exp_b[cyc] = 2'b00;
        if (en && v) begin
            pair   = 2'($urandom);
            prev   = cur_st;
            cur_st = {prev[SB-3:0], pair};
            word[{cur_st, 1'b0} +: 2] = prev[SB-1:SB-2];
            if (!rnd_best) best_i = cur_st;
            dec_hist[g]  = word;
            pair_hist[g] = pair;
            if (fb == STEPS) begin
                exp_v[cyc] = 1'b1;
                if (rnd_best) begin
                    exp_b[cyc] = model_walk(g, best_i);
                    exp_r[cyc] = "R3";
                end else begin
                    exp_b[cyc] = pair_hist[g - STEPS];
                    exp_r[cyc] = (g > 4 * BUFS) ? "R9" : "R4";
                end
            end else begin
                exp_r[cyc] = "R5";
                fb++;
            end
            g++;
        end else begin
            exp_r[cyc] = en ? "R6" : "R7";
            if (!en) fb = 0;
        end
        en_i  = en;
        vld_i = v;
        dec_i = word;
        @(posedge clk);
        @(negedge clk);
        k = cyc - LAT + 1;
        if (k < 0) begin
            compare("R1", vld_o, 1'b0, bits_o, 2'b00);
        end else begin
            compare(exp_v[k] ? "R2" : exp_r[k], vld_o, exp_v[k], bits_o, exp_b[k]);
            compare(exp_v[k] ? exp_r[k] : "R8", vld_o, exp_v[k], bits_o, exp_b[k]);
        end
        cyc++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; en_i = 1'b0; vld_i = 1'b0; dec_i = '0; best_i = '0;
        repeat (3) begin
            @(negedge clk);
            compare("R1", vld_o, 1'b0, bits_o, 2'b00);
        end
        rst = 1'b0;
        // Continuous stream on an encoder-consistent path.
        for (int i = 0; i < 200; i++) step(1'b1, 1'b1, 1'b0);
        // Random gaps in the input strobe.
        for (int i = 0; i < 250; i++) step(1'b1, 1'($urandom % 2), 1'b0);
        // Arbitrary best states, mostly valid.
        for (int i = 0; i < 250; i++) step(1'b1, 1'(($urandom % 4) != 0), 1'b1);
        // Enable low with the strobe held high.
        for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 1'b0);
        // Refill after enable returns.
        for (int i = 0; i < 120; i++) step(1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 60; i++) step(1'b1, 1'($urandom % 2), 1'b1);
        // Drain.
        for (int i = 0; i < LAT + 3; i++) step(1'b0, 1'b0, 1'b0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule